// File: doc/BRIEF.md
# Event Status Flags and Interrupt Combiner

This block keeps the sticky status word of a twelve-channel converter that runs two conversion sequences, called A and B. Single-cycle event pulses set the flags. There is one pulse per channel for a threshold hit and one for a result overrun. Each sequence also has a global-overrun pulse and a completion pulse. Software clears flags by writing a word in which each 1 clears the flag at that position. The two top bits of the word are summaries derived from the stored flags. A single interrupt line is formed from the summaries and from the sequence flags, each sequence flag gated by its own enable.

A small register port does two jobs. Address 0 is the flag word, and a write to it clears flags. Address 1 is a 3-bit interrupt enable register. A combinational read port returns either register. The flag word is also driven on a port of its own.

Top module: `evt_status_irq`

## Requirements
- R1: During and right after reset, every flag bit, the enable register and the interrupt line are 0.
- R2: A pulse on channel k's threshold input sets flag bit k (bits 11..0) on the next clock edge.
- R3: A pulse on channel k's overrun input sets flag bit 12+k (bits 23..12) on the next clock edge.
- R4: The sequence A and sequence B global-overrun pulses set bits 24 and 25. The sequence A and sequence B completion pulses set bits 28 and 29. Each takes effect on the next clock edge.
- R5: Writing address 0 clears, on that clock edge, every stored flag whose position in the write data holds 1. Positions holding 0 keep their value.
- R6: If a set pulse and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R7: Bits 27 and 26 always read 0. Write data at positions 26, 27, 30 and 31 has no effect on the stored flags.
- R8: Bit 30 is 1 exactly when at least one of bits 11..0 is 1.
- R9: Bit 31 is 1 exactly when enable bit 2 is 1 and at least one of bits 25..12 is 1.
- R10: A write to address 1 loads data bits 2..0 into the enable register (bit 0 = sequence A, bit 1 = sequence B, bit 2 = overrun). Reading address 1 returns that value with bits 31..3 as 0. Reading address 0 returns the flag word.
- R11: The interrupt output equals (bit 28 AND enable bit 0) OR (bit 29 AND enable bit 1) OR bit 30 OR bit 31.
- R12: A flag with no set pulse and no clearing write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_evt_i | input | NUM_CH | Per-channel threshold event pulses |
| ovr_evt_i | input | NUM_CH | Per-channel result overrun pulses |
| seq_ovr_evt_i | input | 2 | Global overrun pulses, bit 0 = A, bit 1 = B |
| seq_done_evt_i | input | 2 | Sequence completion pulses, bit 0 = A, bit 1 = B |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 flag word, 1 enable register |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 1 | Read address: 0 flag word, 1 enable register |
| rd_data_o | output | DATA_W | Read data |
| flags_o | output | DATA_W | Current flag word |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its defaults: NUM_CH = 12 and DATA_W = 32. With these values the layout fills every bit of the word, including the unused pair at 26..27 and the two derived summary bits at the top. Random sparse pulses, together with random clearing writes and enable writes, reach set/clear collisions on single bits. They also reach enable changes that switch the overrun summary while the flags underneath stay set. Directed steps cover partial clears, the same-cycle collision and enable read-back with the upper data bits driven high.

// File: rtl/esi_pkg.sv
package esi_pkg;
   // register port addresses
   typedef enum logic {
      ADDR_FLAGS  = 1'b0,
      ADDR_ENABLE = 1'b1
   } esi_addr_e;

   localparam int NUM_SEQ = 2;
   localparam int ENW     = 3;
   localparam int EN_SEQA = 0;
   localparam int EN_SEQB = 1;
   localparam int EN_OVR  = 2;
   localparam int RSV_W   = 2;
endpackage

// File: rtl/esi_w1c_bank.sv
module esi_w1c_bank #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("esi_w1c_bank: W must be positive");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[b]) q <= 1'b1;
         else if (clr_i[b]) q <= 1'b0;
      end
      assign q_o[b] = q;

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q_o[b]);
      // R5
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !q_o[b]);
      // R12
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[b] && !set_i[b]) |=> $stable(q_o[b]));
   end
endmodule

// File: rtl/esi_enable_reg.sv
module esi_enable_reg
   import esi_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_i,
   input  logic [ENW-1:0] d_i,
   output logic [ENW-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   // R10
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> q_o == $past(d_i));
   // R10
   en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/esi_summary.sv
module esi_summary
   import esi_pkg::*;
#(
   parameter int NUM_CH = 12
) (
   input  logic [NUM_CH-1:0]         thr_flags_i,
   input  logic [NUM_CH+NUM_SEQ-1:0] ovr_flags_i,
   input  logic [NUM_SEQ-1:0]        seq_flags_i,
   input  logic [ENW-1:0]            en_i,
   output logic                      thr_sum_o,
   output logic                      ovr_sum_o,
   output logic                      irq_o
);
   logic [NUM_SEQ-1:0] seq_gated;

   for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
      localparam int EN_IDX = (s == 0) ? EN_SEQA : EN_SEQB;
      assign seq_gated[s] = seq_flags_i[s] & en_i[EN_IDX];
   end

   always_comb begin
      thr_sum_o = |thr_flags_i;
      ovr_sum_o = en_i[EN_OVR] & (|ovr_flags_i);
      irq_o     = (|seq_gated) | thr_sum_o | ovr_sum_o;
   end
endmodule

// File: rtl/evt_status_irq.sv
module evt_status_irq
   import esi_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   thr_evt_i,
   input  logic [NUM_CH-1:0]   ovr_evt_i,
   input  logic [NUM_SEQ-1:0]  seq_ovr_evt_i,
   input  logic [NUM_SEQ-1:0]  seq_done_evt_i,
   input  logic                wr_en_i,
   input  logic                wr_addr_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   input  logic                rd_addr_i,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic [DATA_W-1:0]   flags_o,
   output logic                irq_o
);
   // word layout, derived from the channel count
   localparam int GOVR_LSB    = 2 * NUM_CH;
   localparam int RSV_LSB     = GOVR_LSB + NUM_SEQ;
   localparam int SEQI_LSB    = RSV_LSB + RSV_W;
   localparam int THR_SUM_BIT = SEQI_LSB + NUM_SEQ;
   localparam int OVR_SUM_BIT = THR_SUM_BIT + 1;
   localparam int WORD_W      = OVR_SUM_BIT + 1;
   localparam int ST_LOW_W    = 2 * NUM_CH + NUM_SEQ;
   localparam int ST_W        = ST_LOW_W + NUM_SEQ;
   localparam logic [DATA_W-1:0] CLR_MASK =
      {{(DATA_W-ST_LOW_W){1'b0}}, {ST_LOW_W{1'b1}}} |
      ({{(DATA_W-NUM_SEQ){1'b0}}, {NUM_SEQ{1'b1}}} << SEQI_LSB);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("evt_status_irq: NUM_CH must be positive");
   end
   if (WORD_W != DATA_W) begin : g_bad_w
      $error("evt_status_irq: flag layout must fill DATA_W exactly");
   end

   logic              wr_flags, wr_enable;
   logic [ST_W-1:0]   set_vec, clr_vec, st_q;
   logic [ENW-1:0]    en_q;
   logic              thr_sum, ovr_sum;

   assign wr_flags  = wr_en_i && (wr_addr_i == ADDR_FLAGS);
   assign wr_enable = wr_en_i && (wr_addr_i == ADDR_ENABLE);
   assign set_vec   = {seq_done_evt_i, seq_ovr_evt_i, ovr_evt_i, thr_evt_i};
   assign clr_vec   = wr_flags ? {wr_data_i[SEQI_LSB +: NUM_SEQ], wr_data_i[ST_LOW_W-1:0]}
                               : '0;

   esi_w1c_bank #(.W(ST_W)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .q_o   (st_q)
   );

   esi_enable_reg i_en (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_enable),
      .d_i   (wr_data_i[ENW-1:0]),
      .q_o   (en_q)
   );

   esi_summary #(.NUM_CH(NUM_CH)) i_sum (
      .thr_flags_i (st_q[NUM_CH-1:0]),
      .ovr_flags_i (st_q[ST_LOW_W-1:NUM_CH]),
      .seq_flags_i (st_q[ST_W-1:ST_LOW_W]),
      .en_i        (en_q),
      .thr_sum_o   (thr_sum),
      .ovr_sum_o   (ovr_sum),
      .irq_o       (irq_o)
   );

   assign flags_o   = {ovr_sum, thr_sum, st_q[ST_W-1:ST_LOW_W], {RSV_W{1'b0}},
                       st_q[ST_LOW_W-1:0]};
   assign rd_data_o = (rd_addr_i == ADDR_ENABLE) ? {{(DATA_W-ENW){1'b0}}, en_q} : flags_o;

   // R7
   rsv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flags && ((wr_data_i & CLR_MASK) == '0) && (set_vec == '0)) |=> $stable(st_q));
   // R8
   thr_sum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[THR_SUM_BIT]) |-> $past(|thr_evt_i));
   // R9
   ovr_sum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[OVR_SUM_BIT]) |-> $past((|{ovr_evt_i, seq_ovr_evt_i}) || wr_enable));
   // R11
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((|set_vec) || wr_enable));
endmodule

// File: tb/test_evt_status_irq.sv
module test_evt_status_irq;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] STORE_MASK = 32'h33FF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] thr_evt, ovr_evt;
   logic [1:0]  sovr_evt, sdone_evt;
   logic        wr_en, wr_addr, rd_addr;
   logic [31:0] wr_data, rd_data, flags;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] m_raw = '0;
   logic [2:0]  m_en  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_status_irq i_evt_status_irq (
      .clk(clk), .rst_n(rst_n), .thr_evt_i(thr_evt), .ovr_evt_i(ovr_evt),
      .seq_ovr_evt_i(sovr_evt), .seq_done_evt_i(sdone_evt),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .flags_o(flags), .irq_o(irq));

   function automatic logic [31:0] exp_word(input logic [31:0] raw, input logic [2:0] en);
      logic [31:0] w;
      w     = raw & STORE_MASK;
      w[30] = |w[11:0];
      w[31] = en[2] & (|w[25:12]);
      return w;
   endfunction

   function automatic logic exp_irq(input logic [31:0] w, input logic [2:0] en);
      return (w[28] & en[0]) | (w[29] & en[1]) | w[30] | w[31];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      logic [31:0] e;
      e = exp_word(m_raw, m_en);
      chk("R2 threshold flags", {20'd0, flags[11:0]}, {20'd0, e[11:0]});
      chk("R3 overrun flags", {20'd0, flags[23:12]}, {20'd0, e[23:12]});
      chk("R4 sequence flags", {28'd0, flags[29:28], flags[25:24]},
          {28'd0, e[29:28], e[25:24]});
      chk("R7 gap bits zero", {30'd0, flags[27:26]}, 32'd0);
      chk("R8 threshold summary", {31'd0, flags[30]}, {31'd0, e[30]});
      chk("R9 overrun summary", {31'd0, flags[31]}, {31'd0, e[31]});
      chk("R11 interrupt line", {31'd0, irq}, {31'd0, exp_irq(e, m_en)});
      chk("R10 read port", rd_data, rd_addr ? {29'd0, m_en} : e);
   endtask

   // drive at a falling edge, update the model, check at the next falling edge
   task automatic cycle(input logic [11:0] t, input logic [11:0] o, input logic [1:0] so,
                        input logic [1:0] sd, input logic we, input logic wa,
                        input logic [31:0] wd, input logic ra);
      logic [31:0] evw, clr;
      thr_evt = t; ovr_evt = o; sovr_evt = so; sdone_evt = sd;
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      evw = {2'b00, sd, 2'b00, so, o, t};
      clr = (we && !wa) ? (wd & STORE_MASK) : 32'd0;
      m_raw = ((m_raw & ~clr) | evw) & STORE_MASK;
      if (we && wa) m_en = wd[2:0];
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      thr_evt = '0; ovr_evt = '0; sovr_evt = '0; sdone_evt = '0;
      wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state, with pulses pending during reset
      thr_evt = 12'hFFF;
      @(negedge clk);
      chk("R1 flags in reset", flags, 32'd0);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      thr_evt = '0;
      rst_n = 1'b1;
      rd_addr = 1'b1;
      @(negedge clk);
      chk("R1 enable after reset", rd_data, 32'd0);
      chk("R1 flags after reset", flags, 32'd0);

      // R2 / R5: set two channels, clear one of them
      cycle(12'h088, '0, '0, '0, 0, 0, '0, 0);
      cycle('0, '0, '0, '0, 1, 0, 32'h0000_0008, 0);
      chk("R5 written one clears", {31'd0, flags[3]}, 32'd0);
      chk("R5 written zero keeps", {31'd0, flags[7]}, 32'd1);

      // R6: same-cycle set and clear on bit 5
      cycle(12'h020, '0, '0, '0, 1, 0, 32'h0000_0020, 0);
      chk("R6 set wins over clear", {31'd0, flags[5]}, 32'd1);

      // R7: write ones only at gap and summary positions
      cycle('0, '0, '0, '0, 1, 0, 32'hCC00_0000, 0);
      chk("R7 gap write ignored", flags & STORE_MASK, m_raw);

      // R10: enable register with high data bits set
      cycle('0, '0, '0, '0, 1, 1, 32'hFFFF_FFF9, 1);
      chk("R10 enable readback", rd_data, 32'd1);

      // R4 / R11: sequence A completion with its enable on
      cycle('0, '0, '0, '0, 1, 0, 32'hFFFF_FFFF, 0);
      cycle('0, '0, '0, 2'b01, 0, 0, '0, 0);
      chk("R11 seq A raises irq", {31'd0, irq}, 32'd1);
      cycle('0, '0, '0, 2'b10, 1, 0, 32'h1000_0000, 0);
      chk("R11 seq B masked", {31'd0, irq}, 32'd0);

      // R9: overrun summary follows enable bit 2
      cycle('0, 12'h400, 2'b00, '0, 0, 0, '0, 0);
      cycle('0, '0, '0, '0, 1, 1, 32'h0000_0004, 1);
      chk("R9 overrun summary on", {31'd0, flags[31]}, 32'd1);

      // R12: idle cycles keep everything
      for (int i = 0; i < 4; i++) cycle('0, '0, '0, '0, 0, 0, '0, i[0]);
      chk("R12 sticky flags", flags & STORE_MASK, m_raw);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] t, o;
         logic [1:0]  so, sd;
         logic        we, wa;
         t  = 12'($urandom & $urandom & $urandom);
         o  = 12'($urandom & $urandom & $urandom);
         so = 2'($urandom & $urandom);
         sd = 2'($urandom & $urandom);
         we = ($urandom % 3) == 0;
         wa = ($urandom % 6) == 0;
         cycle(t, o, so, sd, we, wa, $urandom, 1'($urandom));
      end
      finish_run();
   end
endmodule